// File: doc/BRIEF.md
# Receive Byte FIFO with Threshold Bus Request

This block buffers the byte stream arriving from a serial network deserializer and hands it to a DMA bus master. Bytes enter one per write strobe. The DMA side drains them either one byte per read or two bytes per read, depending on the transfer mode.

A registered bus request tells the DMA master when enough data has built up to make a burst worthwhile. The fill level that raises the request depends on the programmed threshold and on the transfer mode. After a frame start, the first request of that frame is held back until at least eight bytes are present, so that the destination-address bytes are complete. The DMA master signals the end of each burst. The request then drops if the fill level has fallen below the trigger point.

An overrun flag warns of impending loss while three spare storage slots still remain. The flag stays set until the next frame start.

Top module: `rx_thresh_fifo`

## Requirements
- R1: `thr_sel` selects the threshold: 2'b00 gives 2 bytes, 2'b01 gives 4 bytes, and 2'b10 or 2'b11 give 8 bytes. In word mode these are 1, 2 or 4 words.
- R2: In byte mode (`word_mode`=0), after the first request of a frame, `bus_req` rises at the clock edge that brings the fill level to threshold+1 bytes.
- R3: In word mode (`word_mode`=1), after the first request of a frame, `bus_req` rises at the clock edge that brings the fill level to threshold+2 bytes.
- R4: After reset or a `sof` pulse, the first request needs the fill level to reach the larger of 8 and the R2/R3 trigger level.
- R5: Once raised, `bus_req` stays high until one of two things happens. Either `burst_done` is high in a cycle whose resulting fill level is below the R2/R3 trigger, or `sof` is pulsed. Only after it has dropped may it rise again.
- R6: `overrun` sets at the edge where a write, counted after that cycle's read, brings the occupancy to 13 or more. It stays set until `sof` (a write reaching 13 in the same cycle wins) or reset.
- R7: Storage holds 16 bytes. A write that finds 16 bytes held, after that cycle's read, is discarded.
- R8: In byte mode a read pops the oldest byte and presents it as `rd_data` = {8'h00, byte} during the read cycle. A read of an empty FIFO is ignored.
- R9: In word mode a read pops two bytes and presents them as `rd_data` = {second byte, first-received byte}. A read with fewer than 2 bytes held is ignored.
- R10: After reset, `bus_req` and `overrun` are low and the FIFO is empty.
- R11: A read and a write in the same cycle change the fill level by their net amount. The request decision and the overrun decision use that net level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Frame start pulse: re-arms the 8-byte first-request hold, clears request and overrun |
| wr_en | input | 1 | Write strobe from the deserializer |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | Read strobe from the DMA side |
| rd_data | output | 16 | Head data, byte in low half or word |
| word_mode | input | 1 | 1 = 16-bit reads, 0 = byte reads |
| thr_sel | input | 2 | Threshold select (R1) |
| burst_done | input | 1 | Pulse marking the last transfer of a DMA burst |
| bus_req | output | 1 | Bus request to the DMA master |
| overrun | output | 1 | Sticky early-overrun flag |

## Verification
The delicate overlap is a burst-completion pulse that arrives in the same cycle as a read and a new incoming byte. The request must then be judged against the net fill level, not the level after the pop alone. The bench holds the request at exactly the trigger level and pulses `burst_done` together with a read and a write. In that case the request must stay up. A second pulse with the read alone must drop it. One further byte must then raise it again at the normal trigger, with no 8-byte hold.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        THR_TWO   = 2'b00,
        THR_FOUR  = 2'b01,
        THR_EIGHT = 2'b10,
        THR_EIGHT_ALT = 2'b11
    } thr_sel_e;

    // Threshold in bytes for a select code.
    function automatic int unsigned thr_bytes(input logic [1:0] sel);
        case (thr_sel_e'(sel))
            THR_TWO:  thr_bytes = 2;
            THR_FOUR: thr_bytes = 4;
            default:  thr_bytes = 8;
        endcase
    endfunction

endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_ok,
    input  logic [W-1:0] wr_data,
    input  logic [1:0]   npop,
    output logic [W-1:0] head0,
    output logic [W-1:0] head1
);
    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
    } ptr_t;

    ptr_t ptr_q, ptr_d;
    logic [W-1:0] store [DEPTH];

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p, input logic [1:0] n);
        logic [PW:0] s;
        s = {1'b0, p} + (PW+1)'(n);
        if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
        adv = s[PW-1:0];
    endfunction

    always_comb begin
        ptr_d      = ptr_q;
        ptr_d.wptr = wr_ok ? adv(ptr_q.wptr, 2'd1) : ptr_q.wptr;
        ptr_d.rptr = adv(ptr_q.rptr, npop);
        head0      = store[ptr_q.rptr];
        head1      = store[adv(ptr_q.rptr, 2'd1)];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) store[ptr_q.wptr] <= wr_data;
    end

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned OVR_AT = 13,
    localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          word_mode,
    output logic          wr_ok,
    output logic [1:0]    npop,
    output logic [LW-1:0] level_q,
    output logic [LW-1:0] level_d,
    output logic          overrun
);
    typedef struct packed {
        logic [LW-1:0] level;
        logic          ovr;
    } st_t;

    st_t st_q, st_d;
    logic [LW-1:0] after_pop, with_wr;

    always_comb begin
        npop = 2'd0;
        if (rd_en) begin
            if (word_mode) begin
                if (st_q.level >= LW'(2)) npop = 2'd2;
            end else if (st_q.level != '0) begin
                npop = 2'd1;
            end
        end
        after_pop = st_q.level - LW'(npop);
        with_wr   = after_pop + LW'(1);
        wr_ok     = wr_en && (after_pop < LW'(DEPTH));
        st_d.level = wr_ok ? with_wr : after_pop;
        st_d.ovr   = sof ? 1'b0 : st_q.ovr;
        if (wr_en && (with_wr >= LW'(OVR_AT))) st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_q = st_q.level;
    assign level_d = st_d.level;
    assign overrun = st_q.ovr;

    // R7: a lone write into a full store leaves it full, no wrap to empty
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && st_q.level == LW'(DEPTH)) |=> st_q.level == LW'(DEPTH));

    // R6: the flag only comes up with the occupancy at the early mark
    p_ovr_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> st_q.level >= LW'(OVR_AT));

    // R6: the flag is only cleared by a frame start
    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.ovr) |-> $past(sof));

endmodule

// File: rtl/rxf_req.sv
module rxf_req #(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned FIRST_MIN = 8,
    localparam int unsigned LW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sof,
    input  logic          burst_done,
    input  logic          word_mode,
    input  logic [1:0]    thr_sel,
    input  logic [LW-1:0] level_q,
    input  logic [LW-1:0] level_d,
    output logic          bus_req
);
    import rxf_pkg::*;

    typedef struct packed {
        logic req;
        logic first;
    } st_t;

    st_t st_q, st_d;
    logic [LW-1:0] trig, first_trig, need;

    always_comb begin
        trig       = LW'(thr_bytes(thr_sel)) + (word_mode ? LW'(2) : LW'(1));
        first_trig = (trig > LW'(FIRST_MIN)) ? trig : LW'(FIRST_MIN);
        need       = st_q.first ? first_trig : trig;
        st_d       = st_q;
        if (sof) begin
            st_d.req   = 1'b0;
            st_d.first = 1'b1;
        end else if (st_q.req) begin
            if (burst_done && (level_d < trig)) st_d.req = 1'b0;
        end else if (level_d >= need) begin
            st_d.req   = 1'b1;
            st_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{req: 1'b0, first: 1'b1};
        else        st_q <= st_d;
    end

    assign bus_req = st_q.req;

    // R4: first request of a frame never comes below the address window
    p_first_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.req) && $past(st_q.first)) |-> level_q >= LW'(FIRST_MIN));

    // R5: request falls only on burst completion or frame start
    p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.req) |-> $past(burst_done || sof));

    // R2: no request with less than the smallest possible trigger
    p_req_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.req) |-> level_q >= LW'(3));

endmodule

// File: rtl/rx_thresh_fifo.sv
module rx_thresh_fifo #(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned OVR_AT    = 13,
    parameter int unsigned FIRST_MIN = 8,
    localparam int unsigned W        = rxf_pkg::BYTE_W,
    localparam int unsigned LW       = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sof,
    input  logic           wr_en,
    input  logic [W-1:0]   wr_data,
    input  logic           rd_en,
    output logic [2*W-1:0] rd_data,
    input  logic           word_mode,
    input  logic [1:0]     thr_sel,
    input  logic           burst_done,
    output logic           bus_req,
    output logic           overrun
);
    logic          wr_ok;
    logic [1:0]    npop;
    logic [LW-1:0] level_q, level_d;
    logic [W-1:0]  head0, head1;

    rxf_ctrl #(.DEPTH(DEPTH), .OVR_AT(OVR_AT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sof(sof), .wr_en(wr_en), .rd_en(rd_en),
        .word_mode(word_mode), .wr_ok(wr_ok), .npop(npop),
        .level_q(level_q), .level_d(level_d), .overrun(overrun)
    );

    rxf_mem #(.DEPTH(DEPTH), .W(W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_data(wr_data),
        .npop(npop), .head0(head0), .head1(head1)
    );

    rxf_req #(.DEPTH(DEPTH), .FIRST_MIN(FIRST_MIN)) u_req (
        .clk(clk), .rst_n(rst_n), .sof(sof), .burst_done(burst_done),
        .word_mode(word_mode), .thr_sel(thr_sel),
        .level_q(level_q), .level_d(level_d), .bus_req(bus_req)
    );

    always_comb begin
        rd_data = word_mode ? {head1, head0} : {{W{1'b0}}, head0};
    end

endmodule

// File: tb/rx_thresh_fifo_test.sv
`timescale 1ns/1ps
module rx_thresh_fifo_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0, wr_en = 1'b0, rd_en = 1'b0, burst_done = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_data;
    logic        word_mode = 1'b0;
    logic [1:0]  thr_sel = 2'b00;
    logic        bus_req, overrun;

    int errors = 0, checks = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    logic [7:0] seq = 8'h10;

    always #2 clk = ~clk;

    rx_thresh_fifo uut (
        .clk(clk), .rst_n(rst_n), .sof(sof), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .word_mode(word_mode), .thr_sel(thr_sel),
        .burst_done(burst_done), .bus_req(bus_req), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compares head data during every read that the model allows.
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            if (word_mode && exp_q.size() >= 2) begin
                logic [15:0] e;
                e = {exp_q[1], exp_q[0]};
                void'(exp_q.pop_front());
                void'(exp_q.pop_front());
                chk(rd_data == e, "R9 word read", rd_data, e);
            end else if (!word_mode && exp_q.size() >= 1) begin
                logic [15:0] e;
                e = {8'h00, exp_q.pop_front()};
                chk(rd_data == e, "R8 byte read", rd_data, e);
            end
        end
    end

    // Driver: one cycle of stimulus; pushes expected bytes that are kept.
    task automatic step(input bit w, input bit r, input bit bd, input bit s);
        wr_en = w; wr_data = seq; rd_en = r; burst_done = bd; sof = s;
        @(posedge clk);
        if (w) begin
            if (exp_q.size() < 16) exp_q.push_back(seq);
            seq = seq + 8'd1;
        end
        #1;
        wr_en = 0; rd_en = 0; burst_done = 0; sof = 0;
    endtask

    task automatic drain_all();
        int per;
        per = word_mode ? 2 : 1;
        while (exp_q.size() > per) step(0, 1, 0, 0);
        if (exp_q.size() >= per) step(0, 1, 1, 0);
        else step(0, 0, 1, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            chk(0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk(bus_req == 0, "R10 req after reset", bus_req, 0);
        chk(overrun == 0, "R10 overrun after reset", overrun, 0);
        rst_n = 1'b1;
        step(0, 1, 0, 0);   // read of empty is ignored (R8)

        // R1..R4: trigger byte counts for every mode and select code
        for (int m = 0; m < 2; m++) begin
            for (int sel = 0; sel < 4; sel++) begin
                int thr, trig, first;
                word_mode = m[0];
                thr_sel   = sel[1:0];
                thr   = (sel == 0) ? 2 : (sel == 1) ? 4 : 8;
                trig  = thr + (m ? 2 : 1);
                first = (trig > 8) ? trig : 8;
                step(0, 0, 0, 1);
                for (int n = 1; n <= first; n++) begin
                    step(1, 0, 0, 0);
                    chk(bus_req == (n >= first), "R4 first request R1", bus_req, n >= first);
                end
                drain_all();
                chk(bus_req == 0, "R5 drop after burst", bus_req, 0);
                for (int n = 1; n <= trig; n++) begin
                    step(1, 0, 0, 0);
                    if (m) chk(bus_req == (n >= trig), "R3 word trigger", bus_req, n >= trig);
                    else   chk(bus_req == (n >= trig), "R2 byte trigger", bus_req, n >= trig);
                end
                drain_all();
                chk(bus_req == 0, "R5 drop after second burst", bus_req, 0);
            end
        end

        // R5 / R11: burst end coinciding with read and write
        word_mode = 0; thr_sel = 2'b00;
        step(0, 0, 0, 1);
        for (int n = 0; n < 8; n++) step(1, 0, 0, 0);
        chk(bus_req == 1, "R4 first at 8 bytes", bus_req, 1);
        for (int n = 0; n < 5; n++) step(0, 1, 0, 0);
        chk(bus_req == 1, "R5 held without burst end", bus_req, 1);
        step(1, 1, 1, 0);
        chk(bus_req == 1, "R11 net level at trigger keeps req", bus_req, 1);
        step(0, 1, 1, 0);
        chk(bus_req == 0, "R5 drop below trigger", bus_req, 0);
        step(1, 0, 0, 0);
        chk(bus_req == 1, "R2 rerequest at normal trigger", bus_req, 1);
        drain_all();

        // R6 / R7: early overrun and full-store drop
        step(0, 0, 0, 1);
        for (int n = 1; n <= 12; n++) step(1, 0, 0, 0);
        chk(overrun == 0, "R6 no overrun at 12", overrun, 0);
        step(1, 0, 0, 0);
        chk(overrun == 1, "R6 overrun at 13", overrun, 1);
        for (int n = 14; n <= 17; n++) step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        chk(overrun == 1, "R6 overrun sticky", overrun, 1);
        chk(exp_q.size() == 15, "R7 model depth", exp_q.size(), 15);
        drain_all();
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);   // R7: monitor expects the new byte, not the dropped one
        step(0, 0, 0, 1);
        chk(overrun == 0, "R6 cleared by frame start", overrun, 0);

        // R9: word read with one byte held is ignored
        word_mode = 1;
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        chk(exp_q.size() == 0, "R9 pair consumed", exp_q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule